// File: doc/BRIEF.md
# Fault Shutdown Controller with Open-Drain Hold

This block supervises a shared, active-low shutdown line of a half-bridge gate driver. The same line is read through a pair of threshold detectors and can also be pulled low by an open-drain transistor that the block drives. The block has two results. The first, `force_off`, tells the gate logic to turn both gate outputs off. The second, `od_pull_en`, turns on the pull-down of the shared line.

When a synchronous fault pulse arrives from the overcurrent comparator, `force_off` rises in the same cycle, through a direct combinational path. It does not wait for the line to discharge. From the next clock edge the block holds the line low through the open-drain pull-down. It keeps doing so until the line is seen below its lower threshold, then lets go. After that, an external RC network decides how long the line stays low, and that time is the disable interval. It does not affect how quickly the outputs are cut.

A low level driven onto the line from outside is not latched. The outputs are forced off only while the line reads low, so the line can also carry PWM chopping. Both threshold inputs pass through a synchronizer of `SYNC_STAGES` flops.

Top module: `fault_shutdown_ctrl`

## Requirements
- R1: `force_off` is 1 in the same cycle that `fault_pulse` is 1, before any clock edge.
- R2: `od_pull_en` becomes 1 on the first clock edge at which `fault_pulse` is sampled as 1.
- R3: Once asserted, `od_pull_en` stays 1 while the synchronized `line_below_lo` is 0. It goes to 0 on the edge after the synchronized value is 1, which is `SYNC_STAGES`+1 edges after `line_below_lo` rises.
- R4: When the line is pulled low from outside with no fault, `force_off` follows the line and `od_pull_en` stays 0. Nothing is latched: `force_off` returns to 0 once the line reads high again.
- R5: `force_off` returns to 0 `SYNC_STAGES`+1 clock edges after `line_above_hi` rises, provided the line was low beforehand and no fault is present. This allows repeated chopping through the line.
- R6: The delay from fault to `force_off` is zero cycles, whatever length of disable interval came before the fault.
- R7: After a fault, `force_off` stays 1 until the line has been seen below the lower threshold and then above the upper threshold. A line sitting between the two thresholds keeps `force_off` at 1.
- R8: A fault that arrives while the hold sequence is already running restarts the pull-down, which is 1 on the next edge. `force_off` does not drop at any point during the restart.
- R9: After reset, `od_pull_en` and `force_off` are 0 as long as no fault is present and the line has not been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pulse | input | 1 | Synchronous fault pulse from the overcurrent comparator |
| line_below_lo | input | 1 | Raw detector: the shutdown line is below its lower threshold |
| line_above_hi | input | 1 | Raw detector: the shutdown line is above its upper threshold |
| force_off | output | 1 | Forces both gate outputs off |
| od_pull_en | output | 1 | Turns on the open-drain pull-down of the shutdown line |

## Verification
The results fall due at three different times:
- `force_off` answers a fault with no clock edge.
- `od_pull_en` answers a fault one edge later.
- Any response to a change on the threshold inputs appears `SYNC_STAGES`+1 edges later, which is three with the default setting.

The bench changes inputs only on falling edges and samples just after the following falling edges. A fault is checked 1 ns after it is driven. A threshold change is checked twice: on the falling edge before its result is due, where the old value must still hold, and on the falling edge where the new value must appear. This pins each latency to the exact cycle.

// File: rtl/fault_shutdown_ctrl.sv
module fault_shutdown_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_pulse,
  input  logic line_below_lo,
  input  logic line_above_hi,
  output logic force_off,
  output logic od_pull_en
);

  typedef enum logic [1:0] {ST_IDLE, ST_PULL, ST_WAIT} hold_state_e;

  hold_state_e state, state_nx;
  logic [SYNC_STAGES-1:0] lo_q, hi_q;
  logic lo_s, hi_s, line_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= {lo_q[SYNC_STAGES-2:0], line_below_lo};
      hi_q <= {hi_q[SYNC_STAGES-2:0], line_above_hi};
    end
  end

  assign lo_s = lo_q[SYNC_STAGES-1];
  assign hi_s = hi_q[SYNC_STAGES-1];

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (fault_pulse) state_nx = ST_PULL;
      ST_PULL: if (!fault_pulse && lo_s) state_nx = ST_WAIT;
      ST_WAIT: begin
        if (fault_pulse)  state_nx = ST_PULL;
        else if (hi_s)    state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      line_low <= 1'b0;
    end else begin
      state <= state_nx;
      if (hi_s)      line_low <= 1'b0;
      else if (lo_s) line_low <= 1'b1;
    end
  end

  assign od_pull_en = (state == ST_PULL);
  assign force_off  = fault_pulse | (state != ST_IDLE) | line_low;

  // R1
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> $past(force_off));

  // R2
  pull_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> od_pull_en);

  // R3
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_pull_en && !lo_s) |=> od_pull_en);

  // R3
  pull_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_pull_en && lo_s && !fault_pulse) |=> !od_pull_en);

  // R4
  no_pull_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_off && !fault_pulse) |=> !od_pull_en);

  // R7
  hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off && !hi_s) |=> force_off);

endmodule

// File: tb/sim_fault_shutdown_ctrl.sv
module sim_fault_shutdown_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_pulse = 1'b0;
  logic line_below_lo = 1'b0;
  logic line_above_hi = 1'b1;
  logic force_off, od_pull_en;
  int checks = 0;
  int fails = 0;

  localparam int LAT = 3;

  always #10 clk = ~clk;

  fault_shutdown_ctrl #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_pulse(fault_pulse),
    .line_below_lo(line_below_lo), .line_above_hi(line_above_hi),
    .force_off(force_off), .od_pull_en(od_pull_en)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic set_line(input logic below, input logic above);
    @(negedge clk);
    line_below_lo = below;
    line_above_hi = above;
  endtask

  task automatic fire_fault();
    @(negedge clk);
    fault_pulse = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    step(2);
    check("R9", force_off, 1'b0, "force_off after reset");
    check("R9", od_pull_en, 1'b0, "od_pull_en after reset");
  endtask

  task automatic t_fault_hold_release();
    fire_fault();
    check("R1", force_off, 1'b1, "force_off same cycle as fault");
    check("R1", od_pull_en, 1'b0, "od_pull_en before edge");
    @(negedge clk); fault_pulse = 1'b0; #1;
    check("R2", od_pull_en, 1'b1, "od_pull_en one edge after fault");
    step(10);
    check("R3", od_pull_en, 1'b1, "pull held while line high");
    line_below_lo = 1'b1; line_above_hi = 1'b0;
    step(LAT - 1);
    check("R3", od_pull_en, 1'b1, "pull still on before sync latency");
    step(1);
    check("R3", od_pull_en, 1'b0, "pull released after low seen");
    check("R7", force_off, 1'b1, "force_off held after release");
    line_below_lo = 1'b0;
    step(20);
    check("R7", force_off, 1'b1, "force_off held between thresholds");
    check("R7", od_pull_en, 1'b0, "pull stays off between thresholds");
    line_above_hi = 1'b1;
    step(LAT - 1);
    check("R5", force_off, 1'b1, "force_off before upper latency");
    step(1);
    check("R5", force_off, 1'b0, "force_off cleared after line high");
  endtask

  task automatic t_external_chop();
    for (int p = 0; p < 3; p++) begin
      set_line(1'b1, 1'b0);
      step(LAT - 1);
      check("R4", force_off, 1'b0, "force_off before low latency");
      step(1);
      check("R4", force_off, 1'b1, "force_off follows external low");
      check("R4", od_pull_en, 1'b0, "no pull on external low");
      step(5 + p * 7);
      check("R4", od_pull_en, 1'b0, "no pull during external low");
      line_below_lo = 1'b0; line_above_hi = 1'b1;
      step(LAT);
      check("R5", force_off, 1'b0, "outputs back after chop pulse");
    end
  endtask

  task automatic t_long_hold_fault();
    set_line(1'b1, 1'b0);
    step(200);
    fire_fault();
    check("R6", force_off, 1'b1, "zero-cycle fault response after long hold");
    @(negedge clk); fault_pulse = 1'b0; #1;
    check("R6", od_pull_en, 1'b1, "pull one edge after fault");
    step(1);
    check("R3", od_pull_en, 1'b0, "pull released with line already low");
    set_line(1'b0, 1'b1);
    step(LAT);
    check("R5", force_off, 1'b0, "recovered after long hold");
  endtask

  task automatic t_refault();
    fire_fault();
    @(negedge clk); fault_pulse = 1'b0; #1;
    for (int i = 0; i < 4; i++) begin
      check("R8", force_off, 1'b1, "force_off before refault");
      @(negedge clk); #1;
    end
    fault_pulse = 1'b1; #1;
    check("R8", force_off, 1'b1, "force_off during refault in pull");
    @(negedge clk); fault_pulse = 1'b0; #1;
    check("R8", od_pull_en, 1'b1, "pull still on after refault");
    line_below_lo = 1'b1; line_above_hi = 1'b0;
    step(LAT);
    check("R8", od_pull_en, 1'b0, "pull released before second refault");
    fault_pulse = 1'b1; #1;
    check("R8", force_off, 1'b1, "force_off during refault in wait");
    @(negedge clk); fault_pulse = 1'b0; #1;
    check("R8", od_pull_en, 1'b1, "pull restarted from wait");
    check("R8", force_off, 1'b1, "no glitch on restart");
    step(1);
    check("R3", od_pull_en, 1'b0, "pull released again");
    line_below_lo = 1'b0; line_above_hi = 1'b1;
    step(LAT);
    check("R5", force_off, 1'b0, "recovered after refaults");
  endtask

  initial begin
    #5000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_fault_hold_release();
    t_external_chop();
    t_long_hold_fault();
    t_refault();
    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule